// File: doc/BRIEF.md
# Chroma DC 2x2 Hadamard Transform

This block takes the four DC terms of one chroma 8x8 region, one value per 4x4 sub-block, arriving as their own stream separate from the AC coefficients. The chroma intra predictor supplies these values already summed. Once the fourth value has arrived, the block streams out the four coefficients of the 2x2 Hadamard transform over four consecutive cycles. Input samples arrive in raster order (top-left a, top-right b, bottom-left c, bottom-right d). The outputs are, in order, c0 = a+b+c+d, c1 = a-b+c-d, c2 = a+b-c-d and c3 = a-b-c+d.

The 2x2 Hadamard matrix is its own inverse up to a factor of four, so the same module also serves the dequantise and reconstruct side of the transform feedback loop. Any scaling is left to the dequantiser. The block sits inside the intra feedback loop, which runs on the double-rate clock and has 512 cycles per macroblock. For that reason it is built for the shortest possible gap between the last input and the first output: c0 appears in the cycle right after the fourth sample is taken. It also accepts a new group while the previous one is still being emitted, so groups can stream back to back at one sample per cycle.

Two state machines do the work. The collector has states SLOT_A, SLOT_B, SLOT_C and SLOT_D. It moves to the next slot on each accepted sample and wraps from SLOT_D to SLOT_A. An accepted sample in SLOT_D loads the result bank. The emitter has states EMIT_IDLE, EMIT_C0, EMIT_C1, EMIT_C2 and EMIT_C3. It goes from EMIT_IDLE to EMIT_C0 on a load and then steps through C0, C1, C2 and C3. From EMIT_C3 it returns to EMIT_C0 if a load arrives in that cycle, and otherwise to EMIT_IDLE.

Top module: `chroma_dc_hadamard`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` is 0, and the collector waits for the first sample of a group.
- R2: The four outputs of a group appear in the order c0 = a+b+c+d, c1 = a-b+c-d, c2 = a+b-c-d, c3 = a-b-c+d, where a, b, c, d are the accepted samples in arrival (raster) order. All values are two's complement signed.
- R3: `out_data` is two bits wider than `in_data` and never overflows, including when all four inputs are at the most negative or the most positive value.
- R4: The first output (c0) is valid in the cycle right after the clock edge that accepts the fourth sample, and not before that edge.
- R5: `out_valid` is high for exactly four consecutive cycles per group, so every high run of `out_valid` lasts a multiple of four cycles.
- R6: A sample is taken only when `in_valid` is 1. Data with `in_valid` at 0 is ignored, gaps of any length between samples are allowed, and a partial group produces no output.
- R7: Groups may follow each other with no idle cycle. The outputs of consecutive groups then form one continuous `out_valid` run, and no group is lost.
- R8: A second instance fed with the first instance's output stream returns four times the original samples in raster order, so the same module serves as the inverse transform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate transform-loop clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A DC sample is present on in_data |
| in_data | input | IN_W | Signed sub-block DC value, raster order |
| out_valid | output | 1 | A transform coefficient is present on out_data |
| out_data | output | IN_W+2 | Signed coefficient, c0 to c3 in order |

## Verification
The hardest situation to reach is the collision where the fourth sample of a new group is taken in the same cycle that the emitter shows c3 of the previous group. A wrong bank load or a wrong emitter transition there would drop or corrupt a whole group. The bench reaches this collision thousands of times by sweeping every input combination of a 3-bit configuration back to back with no idle cycles, and it chains a second instance as the inverse, so that any slip in ordering or timing shows up as a wrong round-trip value. Separate directed sequences add long gaps, garbage data on idle cycles and a partial group left hanging, to exercise the ignore and latency rules on their own.

// File: rtl/chroma_dc_pkg.sv
package chroma_dc_pkg;

    // Number of sub-block DC values in one chroma region and extra output bits
    localparam int GROUP_LEN = 4;
    localparam int GROW_BITS = 2;

    // Collector: which raster slot the next accepted sample fills
    typedef enum logic [1:0] {
        SLOT_A = 2'd0,
        SLOT_B = 2'd1,
        SLOT_C = 2'd2,
        SLOT_D = 2'd3
    } slot_e;

    // Emitter: which coefficient is presented this cycle
    typedef enum logic [2:0] {
        EMIT_IDLE = 3'd0,
        EMIT_C0   = 3'd1,
        EMIT_C1   = 3'd2,
        EMIT_C2   = 3'd3,
        EMIT_C3   = 3'd4
    } emit_e;

    // Sign of Hadamard entry (row k, column j): negative when k&j has odd weight
    function automatic logic hadamard_neg(input int k, input int j);
        logic [1:0] m;
        m = 2'(k & j);
        return m[0] ^ m[1];
    endfunction

endpackage

// File: rtl/dc_collect.sv
module dc_collect
    import chroma_dc_pkg::*;
#(
    parameter int IN_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_data,
    output logic signed [IN_W-1:0] smp [GROUP_LEN],
    output logic                   group_done
);

    slot_e slot_q, slot_d;
    logic signed [IN_W-1:0] held_q [GROUP_LEN-1];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_A;
        end else begin
            slot_q <= slot_d;
        end
    end

    // Next-state logic: advance on each accepted sample
    always_comb begin
        slot_d = slot_q;
        unique case (slot_q)
            SLOT_A: if (in_valid) slot_d = SLOT_B;
            SLOT_B: if (in_valid) slot_d = SLOT_C;
            SLOT_C: if (in_valid) slot_d = SLOT_D;
            SLOT_D: if (in_valid) slot_d = SLOT_A;
            default: slot_d = SLOT_A;
        endcase
    end

    // Sample holding registers for the first three raster positions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < GROUP_LEN - 1; i++) begin
                held_q[i] <= '0;
            end
        end else if (in_valid) begin
            unique case (slot_q)
                SLOT_A:  held_q[0] <= in_data;
                SLOT_B:  held_q[1] <= in_data;
                SLOT_C:  held_q[2] <= in_data;
                SLOT_D:  ;
                default: ;
            endcase
        end
    end

    // Outputs: the last sample passes straight through for minimum latency
    always_comb begin
        for (int i = 0; i < GROUP_LEN - 1; i++) begin
            smp[i] = held_q[i];
        end
        smp[GROUP_LEN-1] = in_data;
        group_done       = in_valid && (slot_q == SLOT_D);
    end

endmodule

// File: rtl/dc_butterfly.sv
module dc_butterfly
    import chroma_dc_pkg::*;
#(
    parameter int IN_W        = 16,
    parameter int BFLY_DIRECT = 0,
    parameter int OUT_W       = IN_W + GROW_BITS
) (
    input  logic signed [IN_W-1:0]  smp  [GROUP_LEN],
    output logic signed [OUT_W-1:0] coef [GROUP_LEN]
);

    logic signed [OUT_W-1:0] ext [GROUP_LEN];

    // Sign-extend every sample to the output width before any addition
    for (genvar j = 0; j < GROUP_LEN; j++) begin : g_ext
        assign ext[j] = OUT_W'(smp[j]);
    end

    if (BFLY_DIRECT == 0) begin : g_two_stage
        // Two adder levels: row pairs first, then combine rows
        logic signed [OUT_W-1:0] top_sum, top_dif, bot_sum, bot_dif;
        always_comb begin
            top_sum = ext[0] + ext[1];
            top_dif = ext[0] - ext[1];
            bot_sum = ext[2] + ext[3];
            bot_dif = ext[2] - ext[3];
            coef[0] = top_sum + bot_sum;
            coef[1] = top_dif + bot_dif;
            coef[2] = top_sum - bot_sum;
            coef[3] = top_dif - bot_dif;
        end
    end else begin : g_direct
        // Signed accumulation along each Hadamard row
        for (genvar k = 0; k < GROUP_LEN; k++) begin : g_row
            always_comb begin
                logic signed [OUT_W-1:0] acc;
                acc = '0;
                for (int j = 0; j < GROUP_LEN; j++) begin
                    if (hadamard_neg(k, j)) begin
                        acc = acc - ext[j];
                    end else begin
                        acc = acc + ext[j];
                    end
                end
                coef[k] = acc;
            end
        end
    end

endmodule

// File: rtl/dc_emit.sv
module dc_emit
    import chroma_dc_pkg::*;
#(
    parameter int OUT_W = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic signed [OUT_W-1:0] coef [GROUP_LEN],
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);

    emit_e state_q, state_d;
    logic signed [OUT_W-1:0] bank_q [GROUP_LEN];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EMIT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: a load in EMIT_C3 chains straight into the next group
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EMIT_IDLE: state_d = load ? EMIT_C0 : EMIT_IDLE;
            EMIT_C0:   state_d = EMIT_C1;
            EMIT_C1:   state_d = EMIT_C2;
            EMIT_C2:   state_d = EMIT_C3;
            EMIT_C3:   state_d = load ? EMIT_C0 : EMIT_IDLE;
            default:   state_d = EMIT_IDLE;
        endcase
    end

    // Result bank, written once per completed group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < GROUP_LEN; i++) begin
                bank_q[i] <= '0;
            end
        end else if (load) begin
            for (int i = 0; i < GROUP_LEN; i++) begin
                bank_q[i] <= coef[i];
            end
        end
    end

    // Output logic
    always_comb begin
        out_valid = 1'b1;
        out_data  = '0;
        unique case (state_q)
            EMIT_IDLE: out_valid = 1'b0;
            EMIT_C0:   out_data  = bank_q[0];
            EMIT_C1:   out_data  = bank_q[1];
            EMIT_C2:   out_data  = bank_q[2];
            EMIT_C3:   out_data  = bank_q[3];
            default:   out_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/chroma_dc_hadamard.sv
module chroma_dc_hadamard
    import chroma_dc_pkg::*;
#(
    parameter  int IN_W        = 16,
    parameter  int BFLY_DIRECT = 0,
    localparam int OUT_W       = IN_W + GROW_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);

    logic signed [IN_W-1:0]  smp  [GROUP_LEN];
    logic signed [OUT_W-1:0] coef [GROUP_LEN];
    logic                    group_done;

    dc_collect #(
        .IN_W (IN_W)
    ) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .smp        (smp),
        .group_done (group_done)
    );

    dc_butterfly #(
        .IN_W        (IN_W),
        .BFLY_DIRECT (BFLY_DIRECT),
        .OUT_W       (OUT_W)
    ) u_butterfly (
        .smp  (smp),
        .coef (coef)
    );

    dc_emit #(
        .OUT_W (OUT_W)
    ) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (group_done),
        .coef      (coef),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/chroma_dc_hadamard_chk.sv
module chroma_dc_hadamard_chk #(
    parameter int IN_W  = 16,
    parameter int OUT_W = IN_W + 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic signed [IN_W-1:0]  in_data,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_data
);

    logic [1:0] ck_cnt;
    logic [1:0] ck_pos;
    logic signed [OUT_W-1:0] ck_smp [3];
    logic signed [OUT_W-1:0] ref_c0;
    logic fourth;

    assign fourth = in_valid && (ck_cnt == 2'd3);
    assign ref_c0 = ck_smp[0] + ck_smp[1] + ck_smp[2] + OUT_W'(in_data);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_cnt <= '0;
            ck_pos <= '0;
            for (int i = 0; i < 3; i++) ck_smp[i] <= '0;
        end else begin
            if (in_valid) begin
                ck_cnt <= ck_cnt + 2'd1;
                if (ck_cnt != 2'd3) ck_smp[ck_cnt] <= OUT_W'(in_data);
            end
            ck_pos <= out_valid ? ck_pos + 2'd1 : 2'd0;
        end
    end

    // R1: no output right after reset release
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    // R2 and R3: first coefficient equals the full-width sum of the group
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fourth |=> (out_data == $past(ref_c0)));

    // R4: c0 follows the fourth sample by exactly one edge
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fourth |=> (out_valid && ck_pos == 2'd0));

    // R5: a valid run always ends on a multiple of four
    p_burst_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> (ck_pos == 2'd0));

    // R6: a new burst only starts after a completed group
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ck_pos == 2'd0) |-> $past(fourth));

endmodule

bind chroma_dc_hadamard chroma_dc_hadamard_chk #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/chroma_dc_hadamard_bench.sv
module chroma_dc_hadamard_bench;

    localparam int IN_W  = 3;
    localparam int MID_W = IN_W + 2;
    localparam int OUT_W = MID_W + 2;
    localparam int NCOMB = 1 << (4 * IN_W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [IN_W-1:0]  in_data = '0;
    logic                    mid_valid;
    logic signed [MID_W-1:0] mid_data;
    logic                    inv_valid;
    logic signed [OUT_W-1:0] inv_data;

    always #4 clk = ~clk;

    chroma_dc_hadamard #(.IN_W(IN_W)) u_chroma_dc_hadamard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(mid_valid), .out_data(mid_data));

    chroma_dc_hadamard #(.IN_W(MID_W), .BFLY_DIRECT(1)) u_inverse (
        .clk(clk), .rst_n(rst_n), .in_valid(mid_valid), .in_data(mid_data),
        .out_valid(inv_valid), .out_data(inv_data));

    int checks = 0;
    int fails = 0;
    int fwd_q[$];
    int inv_q[$];
    int run_len = 0;
    int longest = 0;
    int cycles = 0;
    string tag = "R2";

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sx(input int raw);
        return (raw >= (1 << (IN_W - 1))) ? raw - (1 << IN_W) : raw;
    endfunction

    task automatic send(input int v);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data  = IN_W'(v);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_data  = IN_W'(i + 5);   // garbage while idle (R6)
        end
    endtask

    task automatic expect_group(input int a, input int b, input int c, input int d);
        fwd_q.push_back(a + b + c + d);
        fwd_q.push_back(a - b + c - d);
        fwd_q.push_back(a + b - c - d);
        fwd_q.push_back(a - b - c + d);
        inv_q.push_back(4 * a);
        inv_q.push_back(4 * b);
        inv_q.push_back(4 * c);
        inv_q.push_back(4 * d);
    endtask

    task automatic group(input int a, input int b, input int c, input int d);
        expect_group(a, b, c, d);
        send(a); send(b); send(c); send(d);
    endtask

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mid_valid) begin
                run_len++;
                if (fwd_q.size() == 0) begin
                    check(1'b0, "R6 unexpected forward output", int'(mid_data), 0);
                end else begin
                    int e;
                    e = fwd_q.pop_front();
                    check(int'(mid_data) == e, {tag, " forward coefficient"}, int'(mid_data), e);
                end
            end else begin
                if (run_len != 0) begin
                    check(run_len % 4 == 0, "R5 valid run length", run_len, 4);
                    if (run_len > longest) longest = run_len;
                end
                run_len = 0;
            end
            if (inv_valid) begin
                if (inv_q.size() == 0) begin
                    check(1'b0, "R8 unexpected inverse output", int'(inv_data), 0);
                end else begin
                    int e;
                    e = inv_q.pop_front();
                    check(int'(inv_data) == e, "R8 round trip", int'(inv_data), e);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "watchdog expired", cycles, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!mid_valid && !inv_valid, "R1 valid during reset", int'(mid_valid), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!mid_valid, "R1 valid after release", int'(mid_valid), 0);
        idle(3);
        @(negedge clk);
        check(!mid_valid, "R1 idle after reset", int'(mid_valid), 0);

        // R6: gaps, garbage and a hanging partial group
        tag = "R6";
        expect_group(1, 2, 3, -1);
        send(1); idle(3); send(2); idle(2); send(3); idle(10);
        @(negedge clk);
        check(!mid_valid, "R6 partial group silent", int'(mid_valid), 0);
        // R4: fourth sample driven; nothing before its capture edge
        send(-1);
        @(negedge clk);
        check(!mid_valid, "R4 early output", int'(mid_valid), 0);
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        check(mid_valid, "R4 first output one cycle after fourth sample", int'(mid_valid), 1);
        idle(8);

        // R3: extremes of the input range
        tag = "R3";
        group(-4, -4, -4, -4);
        group(3, 3, 3, 3);
        group(-4, 3, -4, 3);
        group(-4, -4, 3, 3);
        group(3, -4, -4, 3);
        idle(12);

        // R2 and R7: every input combination, back to back
        tag = "R2 R7";
        for (int v = 0; v < NCOMB; v++) begin
            group(sx(v & 7), sx((v >> 3) & 7), sx((v >> 6) & 7), sx((v >> 9) & 7));
        end
        idle(16);
        @(negedge clk);
        check(fwd_q.size() == 0, "R7 forward groups lost", fwd_q.size(), 0);
        check(inv_q.size() == 0, "R8 inverse groups lost", inv_q.size(), 0);
        check(longest >= 4 * NCOMB, "R7 continuous run", longest, 4 * NCOMB);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule